// File: doc/BRIEF.md
# Multi-mode PRG bank mapper

This block sits between a CPU address bus and a program ROM. It translates every CPU access in the $6000-$FFFF range into a ROM page number. Software configures it by writing byte-wide registers through a CPU write port. There are four bank registers and four mode registers.

A layout field picks one of three switching layouts:
- one 32 KB window;
- two 16 KB windows, the upper one fixed;
- four 8 KB windows, the last one fixed. In one variant of this layout the bank values are bit-mirrored.

An outer-bank field places the selected banks inside a larger ROM. An enable bit can also map a ROM page into the $6000-$7FFF window, with a page derived differently for each layout.

The result is reported as an 8-bit page number in 8 KB units, together with a flag that says whether the access targets ROM at all. The result is registered and appears one clock after the address is presented.

Top module: `prg_bank_mapper`

## Requirements
- R1: On reset all mode registers become 0x00 and all bank registers 0xFF. While reset is held, `page` and `rom_sel` are 0. Right after reset, a read of $8000 gives page 0x1C and a read of $E000 gives page 0x1F.
- R2: A write to $8000-$8FFF stores `wr_data` into bank register `wr_addr[1:0]`. A write to $D000-$D5FF stores it into mode register `wr_addr[1:0]`. Writes to any other address, including $D600 and $9000, change no register. A write takes effect for accesses in the following cycle.
- R3: Layout 0 is selected by mode register 0 bits 1:0 = 0. For any access in $8000-$FFFF, the page is 4 × B + `rd_addr[14:13]`, where the 32 KB bank B = (bank3 & 7) + 8 × outer.
- R4: In layout 1, the 16 KB bank for $8000-$BFFF is (bank1 & 0x0F) + 16 × outer. For $C000-$FFFF it is 0x0F + 16 × outer. The page is 2 × (16 KB bank) + `rd_addr[13]`.
- R5: In layout 2, the pages for $8000, $A000 and $C000 are (bankN & 0x1F) + 32 × outer, using bank registers 0, 1 and 2 in that order. The page for $E000 is 0x1F + 32 × outer.
- R6: Layout 3 behaves like layout 2, except that the five low bits of each register-derived value are mirrored (bit 0 swapped with bit 4, bit 1 with bit 3) before the outer bank is added. The mirroring also applies to the $6000 page.
- R7: The outer bank is mode register 3 bits 2:0. The upper five bits of mode register 3 have no effect.
- R8: When mode register 0 bit 7 is 1, an access to $6000-$7FFF targets ROM. The page is (4 × bank3 + 3) mod 256 in layout 0, (2 × bank3 + 1) mod 256 in layout 1, and bank3 & 0x1F in layouts 2 and 3. When the bit is 0, such an access has `rom_sel` = 0 and page 0.
- R9: Accesses below $6000 give `rom_sel` = 0 and page 0. Every access in $8000-$FFFF gives `rom_sel` = 1.
- R10: `page` and `rom_sel` are registered. They reflect the `rd_addr` and register contents of the previous clock cycle.
- R11: Mode register 0 bit 2 is ignored in the layout decode. Layout codes 4-7 behave as codes 0-3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | CPU write strobe |
| wr_addr | input | 16 | CPU write address |
| wr_data | input | 8 | CPU write data |
| rd_addr | input | 16 | Address of the current CPU access |
| page | output | 8 | ROM page number in 8 KB units |
| rom_sel | output | 1 | Access targets ROM |

## Verification
On every cycle the assertions check these properties:
- accesses below $6000 never select ROM;
- a disabled $6000 window never selects ROM;
- every access in the upper half selects ROM;
- in the 32 KB layout, the outer bank and the in-bank offset land in the right page bits;
- in the 8 KB layouts, $E000 always reaches the last page of the outer bank.

Some behaviours can only be shown by the bench's scenarios, where the reference model is compared against the design:
- the exact page arithmetic for each layout and bank value;
- the bit-mirroring;
- the window page formulas;
- ignored write addresses;
- the one-cycle timing of a write relative to a read.

// File: rtl/prg_map_pkg.sv
package prg_map_pkg;

  localparam int FINE_W = 5;

  typedef enum logic [1:0] {
    LAY_32K    = 2'd0,
    LAY_16K    = 2'd1,
    LAY_8K     = 2'd2,
    LAY_8K_REV = 2'd3
  } layout_e;

  function automatic logic [FINE_W-1:0] mirror_fine(input logic [FINE_W-1:0] v);
    logic [FINE_W-1:0] r;
    for (int i = 0; i < FINE_W; i++) begin
      r[i] = v[FINE_W-1-i];
    end
    return r;
  endfunction

endpackage

// File: rtl/prg_map_regs.sv
module prg_map_regs #(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 8,
  parameter int NUM_REGS = 4
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             wr_en,
  input  logic [ADDR_W-1:0]                wr_addr,
  input  logic [DATA_W-1:0]                wr_data,
  output logic [NUM_REGS-1:0][DATA_W-1:0]  bank_q,
  output logic [NUM_REGS-1:0][DATA_W-1:0]  mode_q
);
  localparam int IDX_W = $clog2(NUM_REGS);

  logic [IDX_W-1:0] idx;
  logic [3:0]       hi_nib;
  logic [3:0]       sub_nib;
  logic             bank_hit;
  logic             mode_hit;
  logic             unused_wr;

  assign idx      = wr_addr[IDX_W-1:0];
  assign hi_nib   = wr_addr[ADDR_W-1 -: 4];
  assign sub_nib  = wr_addr[ADDR_W-5 -: 4];
  assign bank_hit = wr_en && (hi_nib == 4'h8);
  assign mode_hit = wr_en && (hi_nib == 4'hD) && (sub_nib <= 4'h5);
  assign unused_wr = ^wr_addr[ADDR_W-9:IDX_W];

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        bank_q[i] <= '1;
      end else if (bank_hit && (idx == IDX_W'(i))) begin
        bank_q[i] <= wr_data;
      end
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        mode_q[i] <= '0;
      end else if (mode_hit && (idx == IDX_W'(i))) begin
        mode_q[i] <= wr_data;
      end
    end
  end

endmodule

// File: rtl/prg_map_decode.sv
module prg_map_decode
  import prg_map_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 8,
  parameter int NUM_REGS = 4,
  parameter int OUTER_W  = 3,
  parameter int PAGE_W   = OUTER_W + FINE_W
) (
  input  logic [ADDR_W-1:0]               rd_addr,
  input  logic [NUM_REGS-1:0][DATA_W-1:0] bank_q,
  input  logic [NUM_REGS-1:0][DATA_W-1:0] mode_q,
  output logic [PAGE_W-1:0]               page_d,
  output logic                            rom_d
);
  layout_e                          layout;
  logic                             win_en;
  logic [OUTER_W-1:0]               outer;
  logic [2:0]                       slot;
  logic [NUM_REGS-1:0][FINE_W-1:0]  fine;
  logic                             unused_dec;

  assign layout = layout_e'(mode_q[0][1:0]);
  assign win_en = mode_q[0][DATA_W-1];
  assign outer  = mode_q[NUM_REGS-1][OUTER_W-1:0];
  assign slot   = rd_addr[ADDR_W-1 -: 3];

  // 8 KB values, mirrored in the reversed layout
  for (genvar i = 0; i < NUM_REGS; i++) begin : g_fine
    assign fine[i] = (layout == LAY_8K_REV) ? mirror_fine(bank_q[i][FINE_W-1:0])
                                            : bank_q[i][FINE_W-1:0];
  end

  always_comb begin
    page_d = '0;
    rom_d  = 1'b0;
    if (slot[2]) begin
      rom_d = 1'b1;
      unique case (layout)
        LAY_32K: page_d = {outer, bank_q[3][2:0], rd_addr[14:13]};
        LAY_16K: begin
          if (!rd_addr[14]) page_d = {outer, bank_q[1][3:0], rd_addr[13]};
          else              page_d = {outer, 4'hF, rd_addr[13]};
        end
        default: begin
          unique case (slot[1:0])
            2'd0:    page_d = {outer, fine[0]};
            2'd1:    page_d = {outer, fine[1]};
            2'd2:    page_d = {outer, fine[2]};
            default: page_d = {outer, {FINE_W{1'b1}}};
          endcase
        end
      endcase
    end else if (slot == 3'd3 && win_en) begin
      rom_d = 1'b1;
      unique case (layout)
        LAY_32K: page_d = {bank_q[3][5:0], 2'b11};
        LAY_16K: page_d = {bank_q[3][6:0], 1'b1};
        default: page_d = {{OUTER_W{1'b0}}, fine[3]};
      endcase
    end
  end

  assign unused_dec = ^{rd_addr[12:0], mode_q[1], mode_q[2], mode_q[0][6:2],
                        mode_q[3][7:3], bank_q[0][7:5], bank_q[1][7:5],
                        bank_q[2][7:5], bank_q[3][7]};

endmodule

// File: rtl/prg_bank_mapper.sv
module prg_bank_mapper
  import prg_map_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 8,
  parameter int NUM_REGS = 4,
  parameter int OUTER_W  = 3,
  parameter int PAGE_W   = OUTER_W + FINE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [PAGE_W-1:0] page,
  output logic              rom_sel
);
  logic [NUM_REGS-1:0][DATA_W-1:0] bank_q;
  logic [NUM_REGS-1:0][DATA_W-1:0] mode_q;
  logic [PAGE_W-1:0]               page_d;
  logic                            rom_d;

  prg_map_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_REGS(NUM_REGS)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .bank_q(bank_q), .mode_q(mode_q)
  );

  prg_map_decode #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_REGS(NUM_REGS),
    .OUTER_W(OUTER_W), .PAGE_W(PAGE_W)
  ) u_dec (
    .rd_addr(rd_addr), .bank_q(bank_q), .mode_q(mode_q),
    .page_d(page_d), .rom_d(rom_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      page    <= '0;
      rom_sel <= 1'b0;
    end else begin
      page    <= page_d;
      rom_sel <= rom_d;
    end
  end

endmodule

// File: rtl/prg_bank_mapper_chk.sv
module prg_bank_mapper_chk #(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 8,
  parameter int NUM_REGS = 4,
  parameter int PAGE_W   = 8
) (
  input logic                            clk,
  input logic                            rst,
  input logic [ADDR_W-1:0]               rd_addr,
  input logic [PAGE_W-1:0]               page,
  input logic                            rom_sel,
  input logic [NUM_REGS-1:0][DATA_W-1:0] mode_q
);
  logic unused_chk;
  assign unused_chk = ^{mode_q[1], mode_q[2], mode_q[0][6:2], mode_q[3][7:3]};

  p_low_not_rom_r9: assert property (@(posedge clk) disable iff (rst)
    (rd_addr[15:13] < 3'd3) |=> (!rom_sel && page == '0));

  p_upper_rom_r9: assert property (@(posedge clk) disable iff (rst)
    rd_addr[15] |=> rom_sel);

  p_window_off_r8: assert property (@(posedge clk) disable iff (rst)
    (rd_addr[15:13] == 3'd3 && !mode_q[0][7]) |=> !rom_sel);

  p_outer_32k_r7: assert property (@(posedge clk) disable iff (rst)
    (rd_addr[15] && mode_q[0][1:0] == 2'd0) |=>
      (page[7:5] == $past(mode_q[3][2:0]) && page[1:0] == $past(rd_addr[14:13])));

  p_last_fixed_r5: assert property (@(posedge clk) disable iff (rst)
    (rd_addr[15:13] == 3'd7 && mode_q[0][1]) |=> (page[4:0] == 5'h1F));

endmodule

bind prg_bank_mapper prg_bank_mapper_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .PAGE_W(PAGE_W)
) u_chk (
  .clk(clk), .rst(rst), .rd_addr(rd_addr), .page(page),
  .rom_sel(rom_sel), .mode_q(mode_q)
);

// File: tb/prg_bank_mapper_tb.sv
`timescale 1ns/1ps
module prg_bank_mapper_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [15:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [15:0] rd_addr = '0;
  logic [7:0]  page;
  logic        rom_sel;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  int m_bank[4];
  int m_mode[4];
  int exp_page = 0;
  int exp_rom = 0;
  string exp_tag = "R1";
  bit exp_valid = 0;

  always #2.5 clk = ~clk;

  prg_bank_mapper u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .page(page), .rom_sel(rom_sel)
  );

  function automatic int rev5(input int v);
    int r = 0;
    for (int i = 0; i < 5; i++) if ((v >> i) & 1) r += 1 << (4 - i);
    return r;
  endfunction

  task automatic model(input int a, output int pg, output int rom, output string tag);
    int slot = a / 8192;
    int lay = m_mode[0] % 4;
    int outer = m_mode[3] % 8;
    bit win = m_mode[0] >= 128;
    int b3 = m_bank[3];
    pg = 0; rom = 0;
    if (slot < 3) begin
      tag = "R9";
    end else if (slot == 3) begin
      tag = "R8";
      if (win) begin
        rom = 1;
        case (lay)
          0: pg = (b3 * 4 + 3) % 256;
          1: pg = (b3 * 2 + 1) % 256;
          2: pg = b3 % 32;
          default: pg = rev5(b3 % 32);
        endcase
      end
    end else begin
      rom = 1;
      case (lay)
        0: begin
          tag = "R3";
          pg = ((b3 % 8) + outer * 8) * 4 + (a - 32768) / 8192;
        end
        1: begin
          tag = "R4";
          if (a < 49152) pg = ((m_bank[1] % 16) + outer * 16) * 2 + (a / 8192) % 2;
          else           pg = (15 + outer * 16) * 2 + (a / 8192) % 2;
        end
        default: begin
          int k = slot - 4;
          int v = (k < 3) ? m_bank[k] % 32 : 31;
          if (lay == 3) begin
            tag = "R6";
            if (k < 3) v = rev5(v);
          end else tag = "R5";
          pg = v + outer * 32;
        end
      endcase
    end
    if ((m_mode[0] % 8) >= 4 && slot >= 3) tag = "R11";
  endtask

  // reference model: evaluates state before the edge, then applies the write
  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 4; i++) begin m_bank[i] = 255; m_mode[i] = 0; end
      exp_page = 0; exp_rom = 0; exp_tag = "R1";
    end else begin
      model(int'(rd_addr), exp_page, exp_rom, exp_tag);
      if (wr_en) begin
        if (wr_addr >= 16'h8000 && wr_addr <= 16'h8FFF) m_bank[wr_addr % 4] = int'(wr_data);
        else if (wr_addr >= 16'hD000 && wr_addr <= 16'hD5FF) m_mode[wr_addr % 4] = int'(wr_data);
      end
    end
    exp_valid = 1;
  end

  always @(negedge clk) begin
    if (exp_valid && !done) begin
      checks++;
      if (int'(page) != exp_page || int'(rom_sel) != exp_rom) begin
        errors++;
        $display("FAIL %s model: page=%0h rom=%0d expected page=%0h rom=%0d addr=%h",
                 exp_tag, page, rom_sel, exp_page, exp_rom, rd_addr);
      end
    end
  end

  task automatic chk(input string tag, input int got_pg, input int got_rom,
                     input int e_pg, input int e_rom);
    checks++;
    if (got_pg != e_pg || got_rom != e_rom) begin
      errors++;
      $display("FAIL %s: page=%0h rom=%0d expected page=%0h rom=%0d",
               tag, got_pg, got_rom, e_pg, e_rom);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, input int e_pg, input int e_rom, input string tag);
    @(negedge clk);
    rd_addr = a;
    @(negedge clk);
    chk(tag, int'(page), int'(rom_sel), e_pg, e_rom);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 in reset", int'(page), int'(rom_sel), 0, 0);
    rst = 1'b0;
    rd(16'h8000, 8'h1C, 1, "R1 first page");
    rd(16'hE000, 8'h1F, 1, "R1 last page");
    rd(16'h6000, 0, 0, "R8 window off");
    rd(16'h4123, 0, 0, "R9 low region");
    // R2: ignored addresses, then an alias of bank register 3
    wr(16'hD600, 8'h02);
    wr(16'h9003, 8'h00);
    rd(16'hA000, 8'h1D, 1, "R2 ignored writes");
    wr(16'h8FF3, 8'h05);
    rd(16'h8000, 8'h14, 1, "R2 bank3 write");
    // R7: outer bank, upper bits of mode3 ignored
    wr(16'hD003, 8'hFA);
    rd(16'h8000, 8'h54, 1, "R7 outer 32K");
    rd(16'hE000, 8'h57, 1, "R3 offset");
    // R4
    wr(16'hD000, 8'h01);
    wr(16'h8001, 8'h23);
    rd(16'hA000, 8'h47, 1, "R4 switchable");
    rd(16'hC000, 8'h5E, 1, "R4 fixed");
    wr(16'hD000, 8'h81);
    rd(16'h6000, 8'h0B, 1, "R8 16K window");
    // R5
    wr(16'hD000, 8'h82);
    wr(16'h8000, 8'h2C);
    rd(16'h8000, 8'h4C, 1, "R5 slot0");
    rd(16'hE000, 8'h5F, 1, "R5 fixed");
    rd(16'h6000, 8'h05, 1, "R8 8K window");
    // R6
    wr(16'hD000, 8'h83);
    rd(16'h8000, 8'h46, 1, "R6 mirrored");
    rd(16'h6000, 8'h14, 1, "R6 mirrored window");
    // R8 layout 0 window
    wr(16'hD000, 8'h80);
    rd(16'h6000, 8'h17, 1, "R8 32K window");
    // R11
    wr(16'hD000, 8'h06);
    rd(16'h8000, 8'h4C, 1, "R11 code 6");
    rd(16'h6000, 0, 0, "R11 window off");
    // R10: output holds until next edge
    rd(16'hE000, 8'h5F, 1, "R10 prior");
    @(negedge clk);
    rd_addr = 16'h0000;
    #1;
    chk("R10 latency", int'(page), int'(rom_sel), 8'h5F, 1);
    @(negedge clk);
    chk("R10 update", int'(page), int'(rom_sel), 0, 0);
    // mixed traffic against the model
    for (int n = 0; n < 4000; n++) begin
      @(negedge clk);
      rd_addr = 16'($urandom);
      wr_en = ($urandom % 3) == 0;
      wr_addr = ($urandom % 2) ? (16'h8000 | 16'($urandom % 4))
                               : (16'hD000 | 16'($urandom % 4));
      if (($urandom % 8) == 0) wr_addr = 16'($urandom);
      wr_data = 8'($urandom);
    end
    @(negedge clk);
    wr_en = 1'b0;
    @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule